// File: doc/BRIEF.md
# Indexed Extended Register Port

This block holds a bank of 64 byte-wide extended configuration registers behind two adjacent I/O byte ports. The lower address is the index port and the next address up is the data port. A host reaches a register indirectly. It first writes an index to the index port, then reads or writes the data port once. A single 16-bit write to the index port can also carry the index in its low byte and the data in its high byte. That completes a register write in one access.

A latched index is spent by the first data-port access that follows it. A repeated data-port access without a new index write is ignored. The strap input `base_sel` moves the pair of ports between two base addresses. Every register is driven out on a flat vector for the downstream logic that the registers configure.

Top module: `xreg_port`

## Requirements
- R1: Reset (synchronous, active high) clears all 64 registers to 0x00 and leaves no valid index, so a data-port read right after reset returns 0xFF.
- R2: With `base_sel`=0 the index port is at 0x01CE and the data port at 0x01CF; with `base_sel`=1 they are at 0x03CE and 0x03CF. Accesses to any other address, including the unselected pair, change nothing.
- R3: A byte write of an index (`io_be`=01, index on `io_wdata[7:0]`) followed by a byte write to the data port (`io_be`=01, data on `io_wdata[7:0]`) stores the data. Register k = index−0x80 appears on `regs_flat[8k+7:8k]` after the clock edge that ends the data-write strobe.
- R4: A byte read of the data port (`io_rd`, `io_be`=01) after an index write drives the register on `io_rdata` during that read strobe. Whenever no such valid read is in progress, `io_rdata` is 0xFF.
- R5: Any data-port access, read or write, spends the latched index. A further data-port write leaves every register unchanged, and a further read returns 0xFF, until a new index is written.
- R6: A write with `io_be`=11 to the index port uses `io_wdata[7:0]` as the index and `io_wdata[15:8]` as the data. It updates the register in that one access and leaves no valid index behind.
- R7: Only indices 0x80 to 0xBF address the bank; the last sixteen, 0xB0 to 0xBF, are registers 48 to 63. A write with any other index changes nothing. A read with any other index returns 0xFF.
- R8: Malformed accesses are ignored and do not spend the index. These are: read and write strobes together, byte enables other than 01 or 11, a 16-bit access to the data port, and a 16-bit read.
- R9: A second index write before any data access replaces the first, so the latest index is the one used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 1 | Port base strap: 0 selects 0x01CE, 1 selects 0x03CE |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_be | input | 2 | Byte enables: 01 byte access, 11 word access |
| io_wdata | input | 16 | Write data; byte accesses use the low lane |
| io_rdata | output | 8 | Read data from the data port, 0xFF when not valid |
| regs_flat | output | 512 | All registers, register k at bits 8k+7:8k |

## Verification
Two things can happen in the same cycle: capturing an index and writing a register. This occurs in the 16-bit combined write. The bench provokes it and then follows it at once with a bare data-port write, which must find no index left. It also places data accesses directly after index writes, and index rewrites directly after data accesses. Each outcome is judged against a bench-side model of all 64 registers, compared over the whole flat output.

// File: rtl/xreg_pkg.sv
package xreg_pkg;

    localparam int BYTE_W = 8;
    localparam int IO_AW  = 16;

    localparam logic [IO_AW-1:0] PORT_BASE_PRI = 16'h01CE;
    localparam logic [IO_AW-1:0] PORT_BASE_ALT = 16'h03CE;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_IDX_WR,
        ACC_DAT_WR,
        ACC_DAT_RD,
        ACC_WORD_WR
    } acc_e;

    function automatic logic [IO_AW-1:0] port_base(input logic sel);
        return sel ? PORT_BASE_ALT : PORT_BASE_PRI;
    endfunction

    function automatic logic idx_in_window(input logic [BYTE_W-1:0] idx,
                                           input logic [BYTE_W-1:0] first,
                                           input logic [BYTE_W:0]   count);
        logic [BYTE_W:0] wide_idx;
        logic [BYTE_W:0] wide_lo;
        wide_idx = {1'b0, idx};
        wide_lo  = {1'b0, first};
        return (wide_idx >= wide_lo) && (wide_idx < (wide_lo + count));
    endfunction

endpackage

// File: rtl/xreg_decode.sv
module xreg_decode
    import xreg_pkg::*;
(
    input  logic             base_sel,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [1:0]       io_be,
    output acc_e             acc
);
    logic [IO_AW-1:0] base;
    logic             hit_idx;
    logic             hit_dat;
    logic             is_byte;
    logic             is_word;

    always_comb begin
        base    = port_base(base_sel);
        hit_idx = (io_addr == base);
        hit_dat = (io_addr == base + 16'd1);
        is_byte = (io_be == 2'b01);
        is_word = (io_be == 2'b11);
        acc     = ACC_NONE;
        if (io_wr && !io_rd) begin
            if (hit_idx && is_byte)      acc = ACC_IDX_WR;
            else if (hit_idx && is_word) acc = ACC_WORD_WR;
            else if (hit_dat && is_byte) acc = ACC_DAT_WR;
        end else if (io_rd && !io_wr) begin
            if (hit_dat && is_byte)      acc = ACC_DAT_RD;
        end
    end
endmodule

// File: rtl/xreg_index.sv
module xreg_index
    import xreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] idx,
    output logic              idx_vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx     <= '0;
            idx_vld <= 1'b0;
        end else begin
            unique case (acc)
                ACC_IDX_WR: begin
                    idx     <= wbyte;
                    idx_vld <= 1'b1;
                end
                ACC_DAT_WR, ACC_DAT_RD, ACC_WORD_WR: idx_vld <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xreg_bank.sv
module xreg_bank #(
    parameter int NUM_REGS = 64,
    parameter int W        = 8,
    localparam int OFS_W   = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [OFS_W-1:0]      wofs,
    input  logic [W-1:0]          wdata,
    input  logic [OFS_W-1:0]      rofs,
    output logic [W-1:0]          rdata,
    output logic [NUM_REGS*W-1:0] flat
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                             q <= '0;
            else if (we && wofs == OFS_W'(g))    q <= wdata;
        end
        assign flat[g*W +: W] = q;
    end

    assign rdata = flat[rofs*W +: W];
endmodule

// File: rtl/xreg_port.sv
module xreg_port
    import xreg_pkg::*;
#(
    parameter int              NUM_REGS = 64,
    parameter logic [7:0]      IDX_BASE = 8'h80
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       base_sel,
    input  logic [15:0]                io_addr,
    input  logic                       io_wr,
    input  logic                       io_rd,
    input  logic [1:0]                 io_be,
    input  logic [15:0]                io_wdata,
    output logic [7:0]                 io_rdata,
    output logic [NUM_REGS*8-1:0]      regs_flat
);
    localparam int OFS_W = $clog2(NUM_REGS);

    acc_e              acc;
    logic [BYTE_W-1:0] idx;
    logic              idx_vld;
    logic [BYTE_W-1:0] tgt_idx;
    logic [BYTE_W-1:0] tgt_dat;
    logic              we;
    logic [OFS_W-1:0]  wofs;
    logic [OFS_W-1:0]  rofs;
    logic [BYTE_W-1:0] bank_rd;
    logic              rd_ok;

    xreg_decode u_dec (
        .base_sel (base_sel),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_be    (io_be),
        .acc      (acc)
    );

    xreg_index u_idx (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .wbyte   (io_wdata[7:0]),
        .idx     (idx),
        .idx_vld (idx_vld)
    );

    always_comb begin
        if (acc == ACC_WORD_WR) begin
            tgt_idx = io_wdata[7:0];
            tgt_dat = io_wdata[15:8];
        end else begin
            tgt_idx = idx;
            tgt_dat = io_wdata[7:0];
        end
        we = ((acc == ACC_DAT_WR && idx_vld) || acc == ACC_WORD_WR)
             && idx_in_window(tgt_idx, IDX_BASE, 9'(NUM_REGS));
        wofs  = OFS_W'(tgt_idx - IDX_BASE);
        rofs  = OFS_W'(idx - IDX_BASE);
        rd_ok = (acc == ACC_DAT_RD) && idx_vld
                && idx_in_window(idx, IDX_BASE, 9'(NUM_REGS));
        io_rdata = rd_ok ? bank_rd : 8'hFF;
    end

    xreg_bank #(.NUM_REGS(NUM_REGS), .W(BYTE_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .wofs  (wofs),
        .wdata (tgt_dat),
        .rofs  (rofs),
        .rdata (bank_rd),
        .flat  (regs_flat)
    );
endmodule

// File: rtl/xreg_port_chk.sv
module xreg_port_chk
    import xreg_pkg::*;
#(
    parameter int         NUM_REGS = 64,
    parameter logic [7:0] IDX_BASE = 8'h80
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  io_rd,
    input logic                  io_wr,
    input logic [15:0]           io_wdata,
    input logic [7:0]            io_rdata,
    input logic [NUM_REGS*8-1:0] regs_flat,
    input acc_e                  acc,
    input logic                  idx_vld
);
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && !io_wr) |-> io_rdata == 8'hFF); // R4

    AST_RD_NO_INDEX: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_DAT_RD && !idx_vld) |-> io_rdata == 8'hFF); // R5

    AST_SPENT_WR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_DAT_WR && !idx_vld) |=> $stable(regs_flat)); // R5

    AST_INDEX_SPENT: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_DAT_WR || acc == ACC_DAT_RD || acc == ACC_WORD_WR) |=> !idx_vld); // R6

    AST_INDEX_ARMED: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_IDX_WR) |=> idx_vld); // R9

    AST_WORD_OOR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_WORD_WR && !idx_in_window(io_wdata[7:0], IDX_BASE, 9'(NUM_REGS)))
        |=> $stable(regs_flat)); // R7

    AST_IGNORED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_NONE) |=> ($stable(regs_flat) && idx_vld == $past(idx_vld))); // R8
endmodule

bind xreg_port xreg_port_chk #(.NUM_REGS(NUM_REGS), .IDX_BASE(IDX_BASE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .regs_flat (regs_flat),
    .acc       (acc),
    .idx_vld   (idx_vld)
);

// File: tb/tb_xreg_port.sv
`timescale 1ns/1ps
module tb_xreg_port;
    localparam int          N     = 64;
    localparam logic [15:0] BASE0 = 16'h01CE;
    localparam logic [15:0] BASE1 = 16'h03CE;

    logic         clk = 1'b0;
    logic         rst;
    logic         base_sel;
    logic [15:0]  io_addr;
    logic         io_wr;
    logic         io_rd;
    logic [1:0]   io_be;
    logic [15:0]  io_wdata;
    logic [7:0]   io_rdata;
    logic [N*8-1:0] regs_flat;

    logic [7:0] mdl [N];
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    xreg_port dut (
        .clk(clk), .rst(rst), .base_sel(base_sel), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_be(io_be), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .regs_flat(regs_flat)
    );

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic chk_bank(input string tag);
        logic [N*8-1:0] exp;
        for (int k = 0; k < N; k++) exp[k*8 +: 8] = mdl[k];
        checks++;
        if (regs_flat !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, regs_flat, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input logic [1:0] be, input logic wr,
                          input logic rd, input logic [15:0] wd, output logic [7:0] rv);
        @(negedge clk);
        io_addr = a; io_be = be; io_wr = wr; io_rd = rd; io_wdata = wd;
        #5 rv = io_rdata;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0; io_be = 2'b00; io_addr = 16'h0000; io_wdata = 16'h0000;
    endtask

    task automatic wr_idx(input logic [15:0] b, input logic [7:0] i);
        logic [7:0] rv;
        access(b, 2'b01, 1'b1, 1'b0, {8'h00, i}, rv);
    endtask

    task automatic wr_dat(input logic [15:0] b, input logic [7:0] d);
        logic [7:0] rv;
        access(b + 16'd1, 2'b01, 1'b1, 1'b0, {8'h00, d}, rv);
    endtask

    task automatic rd_dat(input logic [15:0] b, output logic [7:0] rv);
        access(b + 16'd1, 2'b01, 1'b0, 1'b1, 16'h0000, rv);
    endtask

    task automatic t_reset();
        logic [7:0] rv;
        for (int k = 0; k < N; k++) mdl[k] = 8'h00;
        chk_bank("R1 reset clears bank");
        rd_dat(BASE0, rv);
        chk8("R1 no index after reset", rv, 8'hFF);
    endtask

    task automatic t_byte_write_read();
        logic [7:0] rv;
        wr_idx(BASE0, 8'h85); wr_dat(BASE0, 8'h5A); mdl[5] = 8'h5A;
        chk_bank("R3 byte write reg 5");
        wr_idx(BASE0, 8'hB0); wr_dat(BASE0, 8'h11); mdl[48] = 8'h11;
        wr_idx(BASE0, 8'hBF); wr_dat(BASE0, 8'h22); mdl[63] = 8'h22;
        chk_bank("R7 top sixteen map to 48..63");
        wr_idx(BASE0, 8'h85); rd_dat(BASE0, rv);
        chk8("R4 byte read reg 5", rv, 8'h5A);
        wr_idx(BASE0, 8'hBF); rd_dat(BASE0, rv);
        chk8("R4 byte read reg 63", rv, 8'h22);
        #1 chk8("R4 idle rdata", io_rdata, 8'hFF);
    endtask

    task automatic t_single_use();
        logic [7:0] rv;
        wr_idx(BASE0, 8'h90); wr_dat(BASE0, 8'h33); mdl[16] = 8'h33;
        wr_dat(BASE0, 8'h44);
        chk_bank("R5 second data write ignored");
        rd_dat(BASE0, rv);
        chk8("R5 read without index", rv, 8'hFF);
        wr_idx(BASE0, 8'h90); rd_dat(BASE0, rv);
        chk8("R5 fresh index read", rv, 8'h33);
        rd_dat(BASE0, rv);
        chk8("R5 repeated read spent", rv, 8'hFF);
        wr_dat(BASE0, 8'h45);
        chk_bank("R5 write after read spent");
    endtask

    task automatic t_word_write();
        logic [7:0] rv;
        access(BASE0, 2'b11, 1'b1, 1'b0, 16'h7788, rv); mdl[8] = 8'h77;
        chk_bank("R6 word write reg 8");
        wr_dat(BASE0, 8'h99);
        chk_bank("R6 word write leaves no index");
        wr_idx(BASE0, 8'h88); rd_dat(BASE0, rv);
        chk8("R6 word-written value reads back", rv, 8'h77);
    endtask

    task automatic t_base_select();
        logic [7:0] rv;
        base_sel = 1'b1;
        wr_idx(BASE0, 8'h81); wr_dat(BASE0, 8'h12);
        chk_bank("R2 old base ignored when alt selected");
        wr_idx(BASE1, 8'h81); wr_dat(BASE1, 8'h12); mdl[1] = 8'h12;
        chk_bank("R2 alt base write");
        wr_idx(BASE1, 8'h81); rd_dat(BASE1, rv);
        chk8("R2 alt base read", rv, 8'h12);
        wr_idx(BASE1, 8'h81); access(16'h03D0, 2'b01, 1'b1, 1'b0, 16'h00EE, rv);
        wr_dat(BASE1, 8'h13); mdl[1] = 8'h13;
        chk_bank("R2 unrelated address ignored");
        base_sel = 1'b0;
    endtask

    task automatic t_range();
        logic [7:0] rv;
        wr_idx(BASE0, 8'h7F); wr_dat(BASE0, 8'hA1);
        wr_idx(BASE0, 8'hC0); wr_dat(BASE0, 8'hA2);
        access(BASE0, 2'b11, 1'b1, 1'b0, 16'hA340, rv);
        chk_bank("R7 out-of-range writes ignored");
        wr_idx(BASE0, 8'hC0); rd_dat(BASE0, rv);
        chk8("R7 out-of-range read", rv, 8'hFF);
        wr_idx(BASE0, 8'h80); wr_dat(BASE0, 8'hA4); mdl[0] = 8'hA4;
        chk_bank("R7 lowest index 0x80");
    endtask

    task automatic t_malformed();
        logic [7:0] rv;
        wr_idx(BASE0, 8'h82);
        access(BASE0 + 16'd1, 2'b10, 1'b1, 1'b0, 16'hBB00, rv);
        access(BASE0 + 16'd1, 2'b01, 1'b1, 1'b1, 16'h00BC, rv);
        access(BASE0, 2'b11, 1'b0, 1'b1, 16'h0000, rv);
        access(BASE0 + 16'd1, 2'b11, 1'b1, 1'b0, 16'hBD82, rv);
        chk_bank("R8 malformed accesses change nothing");
        wr_dat(BASE0, 8'h55); mdl[2] = 8'h55;
        chk_bank("R8 index survives malformed accesses");
    endtask

    task automatic t_rewrite();
        wr_idx(BASE0, 8'h83); wr_idx(BASE0, 8'h84); wr_dat(BASE0, 8'h66); mdl[4] = 8'h66;
        chk_bank("R9 latest index wins");
    endtask

    initial begin
        rst = 1'b1; base_sel = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0;
        io_be = 2'b00; io_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_byte_write_read();
        t_single_use();
        t_word_write();
        t_base_select();
        t_range();
        t_malformed();
        t_rewrite();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule